// File: doc/BRIEF.md
# Dual Byte Stack with Operand Modes

This block provides the operand storage of a small stack-machine processor: two byte-wide last-in-first-out stacks, a working stack (index 0) and a return stack (index 1). Each command comes with a mode byte whose three upper bits set the access width (one byte or a two-byte short), the stack the operation reads from and writes to, and keep behaviour. A separate push-opposite command sends a result to the stack the operation does not use.

The instruction decoder drives one command per accepted cycle. Values for pushes arrive on `wr_data`, and popped values come back on `rd_data` with a one-cycle `rd_valid` strobe. Keep mode is built from a keep-begin command before the operand pops and a keep-end command after them. Together these return the source pointer to its earlier value, so the operands stay on the stack and the results land above them. Short transfers take two cycles and raise `busy` during the second one.

Top module: `duo_stack`

## Requirements
- R1: During reset and right after it, both pointers are zero and `busy` and `rd_valid` are low.
- R2: Command code 2 (push) is accepted when `cmd_valid` is high and `busy` is low. It writes to the working stack when mode bit 6 is clear and to the return stack when bit 6 is set. In byte mode (mode bit 5 clear) it stores `wr_data[7:0]` and raises that stack's pointer by one.
- R3: Command code 3 (push-opposite) writes to the return stack when mode bit 6 is clear and to the working stack when bit 6 is set.
- R4: A short push (mode bit 5 set) stores `wr_data[15:8]` first and then `wr_data[7:0]`, so the low byte ends on top. `busy` is high in the cycle after acceptance, and any command presented in that cycle is ignored.
- R5: Command code 1 (pop) in byte mode lowers the source pointer by one. In the cycle after acceptance it shows the former top byte on `rd_data[7:0]`, with zero in `rd_data[15:8]`, and raises `rd_valid` for one cycle.
- R6: A short pop returns the top byte as `rd_data[7:0]` and the byte below it as `rd_data[15:8]`. `rd_valid` rises in the cycle after `busy`, and the pointer falls by two.
- R7: Command code 4 (drop) lowers the source pointer by one in byte mode or by two in short mode, and does not raise `rd_valid`.
- R8: Command code 5 (keep-begin) with mode bit 7 set captures the source pointer. Command code 6 (keep-end) with bit 7 set restores the source pointer to the captured value. With bit 7 clear, both commands leave the pointers and the captured value unchanged.
- R9: Pointers wrap modulo 256. A drop at 0 gives 255, and a push at 255 gives 0. No error is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd | input | 3 | Command code |
| op_mode | input | 8 | Mode byte: bit 5 short, bit 6 return, bit 7 keep |
| wr_data | input | 16 | Value to push |
| rd_data | output | 16 | Value popped |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| busy | output | 1 | Second byte of a short transfer in progress |
| ptr_w | output | 8 | Working stack pointer |
| ptr_r | output | 8 | Return stack pointer |

## Verification
Several rules are checked by the assertions on every cycle: the pointer step of a byte push and of a short drop, the single-cycle `busy` window after each short transfer, the `rd_valid` strobe after a byte pop, and pointers that stay fixed on a keep-end whose keep bit is clear. The byte order of short values, the push-opposite routing, and operands surviving a keep sequence with results stacked above them can only be shown by the bench's scenarios. The same holds for wrap-around at both ends and for a command ignored while `busy` is high. In each of these cases the stored bytes have to be popped back and compared with the expected order.

// File: rtl/duo_stack_pkg.sv
package duo_stack_pkg;
   typedef enum logic [2:0] {
      CMD_IDLE     = 3'd0,
      CMD_POP      = 3'd1,
      CMD_PUSH     = 3'd2,
      CMD_XPUSH    = 3'd3,
      CMD_DROP     = 3'd4,
      CMD_KEEP_ON  = 3'd5,
      CMD_KEEP_OFF = 3'd6
   } stk_cmd_e;

   localparam int MODE_SHORT_BIT = 5;
   localparam int MODE_RET_BIT   = 6;
   localparam int MODE_KEEP_BIT  = 7;
   localparam int N_STACKS       = 2;
endpackage

// File: rtl/duo_stack_bank.sv
module duo_stack_bank #(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_en,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              dec_en,
   input  logic [1:0]        dec_amt,
   input  logic              load_en,
   input  logic [PTR_W-1:0]  load_val,
   output logic [PTR_W-1:0]  ptr,
   output logic [DATA_W-1:0] top_byte
);
   localparam int DEPTH = 1 << PTR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (inc_en) mem[ptr] <= wr_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (load_en) ptr <= load_val;
      else if (inc_en)  ptr <= ptr + PTR_W'(1);
      else if (dec_en)  ptr <= ptr - PTR_W'(dec_amt);
   end

   assign top_byte = mem[ptr - PTR_W'(1)];
endmodule

// File: rtl/duo_stack_seq.sv
module duo_stack_seq
   import duo_stack_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cmd_valid,
   input  logic [2:0]                        cmd,
   input  logic [7:0]                        op_mode,
   input  logic [2*DATA_W-1:0]               wr_data,
   input  logic [N_STACKS-1:0][PTR_W-1:0]    ptr,
   input  logic [N_STACKS-1:0][DATA_W-1:0]   top_byte,
   output logic [N_STACKS-1:0]               inc_en,
   output logic [N_STACKS-1:0]               dec_en,
   output logic [N_STACKS-1:0]               load_en,
   output logic [DATA_W-1:0]                 wr_byte,
   output logic [1:0]                        dec_amt,
   output logic [PTR_W-1:0]                  load_val,
   output logic [2*DATA_W-1:0]               rd_data,
   output logic                              rd_valid,
   output logic                              busy
);
   stk_cmd_e          cmd_e;
   logic              f_short, f_ret, f_keep;
   logic              src, tgt, accept, is_push;
   logic              busy_q, pop_q, sel_q;
   logic [DATA_W-1:0] lo_q;
   logic [PTR_W-1:0]  snap_q;

   assign cmd_e   = stk_cmd_e'(cmd);
   assign f_short = op_mode[MODE_SHORT_BIT];
   assign f_ret   = op_mode[MODE_RET_BIT];
   assign f_keep  = op_mode[MODE_KEEP_BIT];
   assign src     = f_ret;
   assign tgt     = (cmd_e == CMD_XPUSH) ? ~f_ret : f_ret;
   assign accept  = cmd_valid && !busy_q;
   assign is_push = (cmd_e == CMD_PUSH) || (cmd_e == CMD_XPUSH);

   always_comb begin
      inc_en   = '0;
      dec_en   = '0;
      load_en  = '0;
      wr_byte  = '0;
      dec_amt  = 2'd1;
      load_val = snap_q;
      if (busy_q) begin
         if (pop_q) dec_en[sel_q] = 1'b1;
         else begin
            inc_en[sel_q] = 1'b1;
            wr_byte       = lo_q;
         end
      end else if (cmd_valid) begin
         case (cmd_e)
            CMD_PUSH, CMD_XPUSH: begin
               inc_en[tgt] = 1'b1;
               wr_byte     = f_short ? wr_data[2*DATA_W-1:DATA_W] : wr_data[DATA_W-1:0];
            end
            CMD_POP:  dec_en[src] = 1'b1;
            CMD_DROP: begin
               dec_en[src] = 1'b1;
               dec_amt     = f_short ? 2'd2 : 2'd1;
            end
            CMD_KEEP_OFF: if (f_keep) load_en[src] = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         pop_q    <= 1'b0;
         sel_q    <= 1'b0;
         lo_q     <= '0;
         snap_q   <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         if (busy_q) begin
            busy_q <= 1'b0;
            if (pop_q) begin
               rd_data  <= {top_byte[sel_q], lo_q};
               rd_valid <= 1'b1;
            end
         end else if (accept) begin
            if (f_short && (is_push || cmd_e == CMD_POP)) begin
               busy_q <= 1'b1;
               pop_q  <= (cmd_e == CMD_POP);
               sel_q  <= (cmd_e == CMD_POP) ? src : tgt;
               lo_q   <= (cmd_e == CMD_POP) ? top_byte[src] : wr_data[DATA_W-1:0];
            end
            if (cmd_e == CMD_POP && !f_short) begin
               rd_data  <= {{DATA_W{1'b0}}, top_byte[src]};
               rd_valid <= 1'b1;
            end
            if (cmd_e == CMD_KEEP_ON && f_keep) snap_q <= ptr[src];
         end
      end
   end

   assign busy = busy_q;
endmodule

// File: rtl/duo_stack.sv
module duo_stack
   import duo_stack_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [2:0]          cmd,
   input  logic [7:0]          op_mode,
   input  logic [2*DATA_W-1:0] wr_data,
   output logic [2*DATA_W-1:0] rd_data,
   output logic                rd_valid,
   output logic                busy,
   output logic [PTR_W-1:0]    ptr_w,
   output logic [PTR_W-1:0]    ptr_r
);
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data_w
      $error("duo_stack: DATA_W out of range");
   end
   if (PTR_W < 2 || PTR_W > 12) begin : g_bad_ptr_w
      $error("duo_stack: PTR_W out of range");
   end

   logic [N_STACKS-1:0][PTR_W-1:0]  ptr;
   logic [N_STACKS-1:0][DATA_W-1:0] top_byte;
   logic [N_STACKS-1:0]             inc_en, dec_en, load_en;
   logic [DATA_W-1:0]               wr_byte;
   logic [1:0]                      dec_amt;
   logic [PTR_W-1:0]                load_val;

   duo_stack_seq #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
      .op_mode(op_mode), .wr_data(wr_data), .ptr(ptr), .top_byte(top_byte),
      .inc_en(inc_en), .dec_en(dec_en), .load_en(load_en), .wr_byte(wr_byte),
      .dec_amt(dec_amt), .load_val(load_val), .rd_data(rd_data),
      .rd_valid(rd_valid), .busy(busy)
   );

   for (genvar s = 0; s < N_STACKS; s++) begin : g_bank
      duo_stack_bank #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_bank (
         .clk(clk), .rst_n(rst_n), .inc_en(inc_en[s]), .wr_byte(wr_byte),
         .dec_en(dec_en[s]), .dec_amt(dec_amt), .load_en(load_en[s]),
         .load_val(load_val), .ptr(ptr[s]), .top_byte(top_byte[s])
      );
   end

   assign ptr_w = ptr[0];
   assign ptr_r = ptr[1];
endmodule

// File: rtl/duo_stack_chk.sv
module duo_stack_chk #(
   parameter int PTR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [2:0]       cmd,
   input logic [7:0]       op_mode,
   input logic             rd_valid,
   input logic             busy,
   input logic [PTR_W-1:0] ptr_w,
   input logic [PTR_W-1:0] ptr_r
);
   logic acc;
   assign acc = cmd_valid && !busy;

   // R2
   push_byte_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd == 3'd2 && !op_mode[6] && !op_mode[5]) |=> ptr_w == PTR_W'($past(ptr_w) + 1));

   // R4
   short_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op_mode[5] && (cmd == 3'd1 || cmd == 3'd2 || cmd == 3'd3)) |=> busy);

   // R4
   busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   // R5
   byte_pop_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd == 3'd1 && !op_mode[5]) |=> rd_valid);

   // R7
   drop_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd == 3'd4 && op_mode[5] && !op_mode[6]) |=> (ptr_w == PTR_W'($past(ptr_w) - 2)) && !rd_valid);

   // R8
   keep_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd == 3'd6 && !op_mode[7]) |=> $stable(ptr_w) && $stable(ptr_r));
endmodule

bind duo_stack duo_stack_chk #(.PTR_W(PTR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
   .op_mode(op_mode), .rd_valid(rd_valid), .busy(busy),
   .ptr_w(ptr_w), .ptr_r(ptr_r)
);

// File: tb/test_duo_stack.sv
module test_duo_stack;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd = 3'd0;
   logic [7:0]  op_mode = 8'd0;
   logic [15:0] wr_data = 16'd0;
   logic [15:0] rd_data;
   logic        rd_valid, busy;
   logic [7:0]  ptr_w, ptr_r;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic [15:0] exp_q[$];

   always #4 clk = ~clk;

   duo_stack i_duo_stack (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
      .op_mode(op_mode), .wr_data(wr_data), .rd_data(rd_data),
      .rd_valid(rd_valid), .busy(busy), .ptr_w(ptr_w), .ptr_r(ptr_r)
   );

   function automatic logic [7:0] md(bit s, bit r, bit k);
      return {k, r, s, 5'b0};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(logic [2:0] c, logic [7:0] m, logic [15:0] d);
      cmd_valid = 1'b1; cmd = c; op_mode = m; wr_data = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd = 3'd0;
      while (busy) @(negedge clk);
   endtask

   task automatic pop_expect(logic [7:0] m, logic [15:0] e);
      exp_q.push_back(e);
      issue(3'd1, m, 16'd0);
   endtask

   // scoreboard monitor: every strobe must match the oldest expected value (R5 R6)
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) chk("R7 unexpected rd_valid", {16'd0, rd_data}, 32'hFFFF_FFFF);
         else chk("R5 R6 popped value", {16'd0, rd_data}, {16'd0, exp_q.pop_front()});
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ptr_w in reset", ptr_w, 0);
      chk("R1 ptr_r in reset", ptr_r, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy/rd_valid after reset", {busy, rd_valid}, 0);

      issue(3'd2, md(0,0,0), 16'h0011);
      chk("R2 working push", ptr_w, 1);
      issue(3'd2, md(0,1,0), 16'h0022);
      chk("R2 return push", {ptr_w, ptr_r}, {8'd1, 8'd1});

      // R4 short push, with a command presented while busy
      cmd_valid = 1'b1; cmd = 3'd2; op_mode = md(1,0,0); wr_data = 16'hA1B2;
      @(negedge clk);
      chk("R4 busy after short push", busy, 1);
      op_mode = md(0,0,0); wr_data = 16'h00EE;
      @(negedge clk);
      cmd_valid = 1'b0; cmd = 3'd0;
      chk("R4 command during busy ignored", {busy, ptr_w}, {1'b0, 8'd3});

      pop_expect(md(0,0,0), 16'h00B2);
      chk("R5 pop lowers pointer", ptr_w, 2);

      issue(3'd3, md(0,0,0), 16'h0033);
      chk("R3 opposite of working", {ptr_w, ptr_r}, {8'd2, 8'd2});
      issue(3'd3, md(0,1,0), 16'h0044);
      chk("R3 opposite of return", {ptr_w, ptr_r}, {8'd3, 8'd2});

      pop_expect(md(1,0,0), 16'hA144);
      chk("R6 short pop working", ptr_w, 1);
      pop_expect(md(1,1,0), 16'h2233);
      chk("R6 short pop return", ptr_r, 0);

      // R8 keep sequence
      issue(3'd2, md(0,0,0), 16'h0055);
      issue(3'd5, md(1,0,1), 16'd0);
      pop_expect(md(1,0,1), 16'h1155);
      chk("R8 pops inside keep", ptr_w, 0);
      issue(3'd6, md(1,0,1), 16'd0);
      chk("R8 keep-end restores", ptr_w, 2);
      issue(3'd2, md(0,0,0), 16'h0066);
      pop_expect(md(0,0,0), 16'h0066);
      pop_expect(md(0,0,0), 16'h0055);
      issue(3'd6, md(0,0,0), 16'd0);
      chk("R8 keep-end without flag", ptr_w, 1);
      issue(3'd5, md(0,0,0), 16'd0);
      issue(3'd6, md(0,0,1), 16'd0);
      chk("R8 keep-begin without flag ignored", ptr_w, 2);

      // R7 drop
      issue(3'd4, md(1,0,0), 16'd0);
      issue(3'd2, md(0,0,0), 16'h0077);
      issue(3'd2, md(0,0,0), 16'h0088);
      issue(3'd2, md(0,0,0), 16'h0099);
      issue(3'd4, md(0,0,0), 16'd0);
      chk("R7 byte drop", {ptr_w, 7'd0, rd_valid}, {8'd2, 8'd0});
      issue(3'd4, md(1,0,0), 16'd0);
      chk("R7 short drop", {ptr_w, 7'd0, rd_valid}, {8'd0, 8'd0});

      // R9 wrap
      issue(3'd4, md(0,0,0), 16'd0);
      chk("R9 underflow wrap", ptr_w, 255);
      issue(3'd2, md(0,0,0), 16'h00AB);
      chk("R9 overflow wrap", ptr_w, 0);
      pop_expect(md(0,0,0), 16'h00AB);
      chk("R9 pop across wrap", ptr_w, 255);

      repeat (2) @(negedge clk);
      chk("R5 R6 all pops returned", exp_q.size(), 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule